// File: doc/BRIEF.md
# Asynchronous 16-bit SRAM Controller

This block lets synchronous on-chip logic use an external asynchronous static RAM of 128K 16-bit words. A client hands over one request at a time through a ready/valid handshake. The request carries a word address, write data, a two-bit lane mask and a read/write flag. The controller then drives the RAM pins for exactly as many system clock cycles as the RAM's timing needs. When the request is finished it raises a one-cycle completion strobe. For a read, the captured word comes with that strobe.

All RAM timing figures are held in nanoseconds and turned into cycle counts when the design is built. Each count is the figure divided by the clock period, rounded up, and never less than one cycle. A single parameter picks between the fast and the slow speed grade. Writes are shaped by the write-enable strobe, and chip enable frames every transaction. After every read the controller holds the data bus free for a recovery window before it drives the bus again. The RAM's data pins appear as three separate signals: the controller's output value, its drive enable and the resolved value seen on the bus.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, and in every idle cycle, chip enable, write enable, output enable and both byte enables are high (inactive), the bus drive enable is low, and `req_ready` is high.
- R2: A write holds chip enable and write enable low together. Lane enable `mem_be_n[0]` is low exactly when `req_mask[0]` is 1 (data bits 7:0), and `mem_be_n[1]` is low exactly when `req_mask[1]` is 1 (bits 15:8). Only the enabled bytes of the addressed word change.
- R3: Write timing per grade: fast is 40 ns pulse, 25 ns setup and 55 ns cycle; slow is 45 ns, 30 ns and 70 ns. Write enable stays low for at least the pulse time. The write data is driven and stable for at least the setup time before write enable rises. Chip enable stays low for at least the write cycle time. Each figure is converted as ceil(ns / clock period), with a minimum of 1.
- R4: The address and lane enables are applied, with chip enable low, one cycle before write enable falls. They do not change while chip enable remains low.
- R5: A read holds chip enable and output enable low with write enable high for at least the access time: 55 ns from address and 25 ns from output enable (fast grade), or 70 ns and 35 ns (slow grade). The data is registered at the last cycle of that window, and a lane whose mask bit is 0 returns zero. Write enable and output enable are never low at the same time.
- R6: The controller drives the data bus only while chip enable is low and output enable is high. It drives for the whole write-enable pulse and for one cycle after write enable rises.
- R7: After output enable rises, the controller waits at least the RAM release time before it drives the bus: 20 ns for the fast grade, 25 ns for the slow grade.
- R8: Only one request is in flight at a time. `req_ready` drops in the cycle after a request is accepted and stays low until the transaction is finished. Each request produces exactly one single-cycle `rsp_done`, in request order.
- R9: A request with mask 00 asserts neither lane enable. A write with mask 00 changes nothing, and a read with mask 00 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit0 = bits 7:0, bit1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read data, valid with rsp_done after a read |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | 2 | RAM lane enables, active low, bit0 = lower byte |
| mem_dq_o | output | 16 | Value driven onto the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM data bus |
| mem_dq_i | input | 16 | Resolved value on the RAM data bus |

## Verification
The hardest case to produce from the ports is a write that starts while the RAM may still be releasing the bus after a read. The stimulus creates it by queuing requests back to back, so that a write is accepted in the first idle cycle after a read. A behavioural RAM model in the bench keeps driving the bus for its full release time after output enable rises. It also returns a garbage pattern until the access time has passed, and it flags any overlap with the controller's drive. The model checks pulse width, data setup, cycle time and address stability at every write, and commits only the enabled lanes. A scoreboard then reads the words back with all lane masks, including 00.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WPUL = 3'd2,
    ST_WEND = 3'd3,
    ST_RACC = 3'd4,
    ST_RHZ  = 3'd5
  } asram_state_e;

  // timing figure selectors
  localparam int unsigned K_WC  = 0;
  localparam int unsigned K_PWE = 1;
  localparam int unsigned K_SD  = 2;
  localparam int unsigned K_AA  = 3;
  localparam int unsigned K_DOE = 4;
  localparam int unsigned K_HZ  = 5;

  function automatic int unsigned grade_ns(input bit fast, input int unsigned k);
    case (k)
      K_WC:    return fast ? 55 : 70;
      K_PWE:   return fast ? 40 : 45;
      K_SD:    return fast ? 25 : 30;
      K_AA:    return fast ? 55 : 70;
      K_DOE:   return fast ? 25 : 35;
      K_HZ:    return fast ? 20 : 25;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles with write enable low: covers pulse, setup and cycle (minus setup/end cycles)
  function automatic int unsigned wr_pulse_cyc(input bit fast, input int unsigned per);
    int unsigned wc;
    wc = cyc_of(grade_ns(fast, K_WC), per);
    return max_of(max_of(cyc_of(grade_ns(fast, K_PWE), per),
                         cyc_of(grade_ns(fast, K_SD), per)),
                  (wc > 2) ? wc - 2 : 1);
  endfunction

  function automatic int unsigned rd_cyc(input bit fast, input int unsigned per);
    return max_of(cyc_of(grade_ns(fast, K_AA), per), cyc_of(grade_ns(fast, K_DOE), per));
  endfunction

  function automatic int unsigned hz_cyc(input bit fast, input int unsigned per);
    return cyc_of(grade_ns(fast, K_HZ), per);
  endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter bit          FAST_GRADE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic ce_act_d,
  output logic drive_d,
  output logic capture,
  output logic xfer_end,
  output logic ce_n,
  output logic we_n,
  output logic oe_n
);

  localparam int unsigned N_PW  = wr_pulse_cyc(FAST_GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_RD  = rd_cyc(FAST_GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_HZ  = hz_cyc(FAST_GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_MAX = max_of(N_PW, max_of(N_RD, N_HZ));
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);

  asram_state_e       st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               ce_n_q, we_n_q, oe_n_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (st_q == ST_RACC) && (cnt_q == '0);
  assign xfer_end  = capture || (st_q == ST_WEND);

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d  = req_write ? ST_WSET : ST_RACC;
          cnt_d = req_write ? '0 : CNT_W'(N_RD - 1);
        end
      end
      ST_WSET: begin
        st_d  = ST_WPUL;
        cnt_d = CNT_W'(N_PW - 1);
      end
      ST_WPUL: begin
        if (cnt_q == '0) st_d = ST_WEND;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_WEND: st_d = ST_IDLE;
      ST_RACC: begin
        if (cnt_q == '0) begin
          st_d  = ST_RHZ;
          cnt_d = CNT_W'(N_HZ - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RHZ: begin
        if (cnt_q == '0) st_d = ST_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign ce_act_d = (st_d == ST_WSET) || (st_d == ST_WPUL) ||
                    (st_d == ST_WEND) || (st_d == ST_RACC);
  assign drive_d  = (st_d == ST_WPUL) || (st_d == ST_WEND);

  // registers: state and glitch-free pin strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ce_n_q <= !ce_act_d;
      we_n_q <= !(st_d == ST_WPUL);
      oe_n_q <= !(st_d == ST_RACC);
    end
  end

  assign ce_n = ce_n_q;
  assign we_n = we_n_q;
  assign oe_n = oe_n_q;

  // R8: a request is taken only once
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R5: never read and write strobes together
  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_q && !oe_n_q));

  // R2: write strobe only inside a selected cycle
  p_we_in_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> !ce_n_q);

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              ce_act_d,
  input  logic              drive_d,
  input  logic              capture,
  input  logic              xfer_end,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q, be_n_q, be_n_d;
  logic              oe_q, done_q;

  // request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_comb begin
    if (!ce_act_d)   be_n_d = '1;
    else if (accept) be_n_d = ~req_mask;
    else             be_n_d = be_n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_n_q <= '1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      be_n_q <= be_n_d;
      oe_q   <= drive_d;
      done_q <= xfer_end;
    end
  end

  // per-lane read capture; disabled lanes return zero
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (capture) lane_q <= mask_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
    end
    assign rsp_rdata[l*8 +: 8] = lane_q;

    // R5 / R9: a masked-off lane reads as zero
    p_lane_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !mask_q[l]) |=> (rsp_rdata[l*8 +: 8] == 8'h00));
  end

  assign mem_addr  = addr_q;
  assign mem_be_n  = be_n_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = oe_q;
  assign rsp_done  = done_q;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter bit          FAST_GRADE    = 1'b1,
  localparam int unsigned LANES        = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned N_HZ  = hz_cyc(FAST_GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_PWE = cyc_of(grade_ns(FAST_GRADE, K_PWE), CLK_PERIOD_NS);
  localparam int unsigned RUN_W = 8;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic accept, ce_act_d, drive_d, capture, xfer_end;

  asram_seq #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .FAST_GRADE    (FAST_GRADE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .ce_act_d  (ce_act_d),
    .drive_d   (drive_d),
    .capture   (capture),
    .xfer_end  (xfer_end),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n)
  );

  asram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .ce_act_d  (ce_act_d),
    .drive_d   (drive_d),
    .capture   (capture),
    .xfer_end  (xfer_end),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_be_n  (mem_be_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  // checker counters: cycles since output enable was low, cycles of write pulse
  logic [RUN_W-1:0] gap_q, wlow_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gap_q  <= RUN_W'(N_HZ);
      wlow_q <= '0;
    end else begin
      if (!mem_oe_n)                gap_q <= '0;
      else if (gap_q < RUN_W'(N_HZ)) gap_q <= gap_q + 1'b1;
      if (mem_we_n)                 wlow_q <= '0;
      else if (wlow_q != '1)        wlow_q <= wlow_q + 1'b1;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe));

  p_drive_window_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_dq_oe |-> (gap_q >= RUN_W'(N_HZ)));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mem_we_n) |-> (wlow_q >= RUN_W'(N_PWE)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

  localparam int CLK = 10;
  localparam bit FAST = 1'b1;
  localparam int T_WC  = FAST ? 55 : 70;
  localparam int T_PWE = FAST ? 40 : 45;
  localparam int T_SD  = FAST ? 25 : 30;
  localparam int T_AA  = FAST ? 55 : 70;
  localparam int T_DOE = FAST ? 25 : 35;
  localparam int T_HZ  = FAST ? 20 : 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr;
  logic [1:0]  mem_be_n;

  always #5 clk = ~clk;

  asram_ctrl #(.CLK_PERIOD_NS(CLK), .FAST_GRADE(FAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int n_chk = 0, n_fail = 0, n_req = 0, n_done = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [15:0] mem [int];
  logic [15:0] mq = '0;
  logic [1:0]  mdrv = '0;

  function automatic logic [15:0] init_word(input logic [16:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] ram_word(input logic [16:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : init_word(a);
  endfunction

  always_comb begin
    for (int l = 0; l < 2; l++)
      mem_dq_i[l*8 +: 8] = mem_dq_oe ? mem_dq_o[l*8 +: 8] : (mdrv[l] ? mq[l*8 +: 8] : 8'h00);
  end

  int rd_run = 0, rel = 0, pulse = 0, dstab = 0, span = 0, oe_hi = 100;
  bit win_prev = 0, span_wr = 0, prev_ce_n = 1, prev_oe = 0;
  logic [16:0] prev_addr = '0, win_addr = '0;
  logic [1:0]  win_be = '1;
  logic [15:0] last_dq = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit rd = !mem_ce_n && !mem_oe_n && mem_we_n;
      automatic bit win = !mem_ce_n && !mem_we_n && (mem_be_n != 2'b11);
      // read side
      if (rd) begin
        rd_run = (rd_run > 0 && mem_addr == prev_addr) ? rd_run + 1 : 1;
        mdrv = ~mem_be_n;
        mq = (rd_run * CLK >= T_AA && rd_run * CLK >= T_DOE) ? ram_word(mem_addr) : 16'hBAD0;
        rel = 0;
      end else begin
        rd_run = 0;
        if (mdrv != 2'b00) begin
          rel++;
          if (rel * CLK - CLK / 2 >= T_HZ) mdrv = 2'b00;
        end
      end
      if (mem_oe_n) oe_hi++; else oe_hi = 0;
      if (mem_dq_oe && mdrv != 2'b00) chk(0, "R7 bus contention", {30'd0, mdrv}, 0);
      if (mem_dq_oe && !prev_oe) chk((oe_hi - 1) * CLK >= T_HZ, "R7 release gap ns", (oe_hi - 1) * CLK, T_HZ);
      // write side
      if (win) begin
        if (!win_prev) begin
          chk(!prev_ce_n && prev_addr == mem_addr, "R4 address before write start", {15'd0, prev_ce_n, 16'd0}, 0);
          pulse = 1; dstab = mem_dq_oe ? 1 : 0;
          win_addr = mem_addr; win_be = mem_be_n;
        end else begin
          pulse++;
          dstab = (mem_dq_oe && mem_dq_i == last_dq) ? dstab + 1 : (mem_dq_oe ? 1 : 0);
          chk(mem_addr == win_addr && mem_be_n == win_be, "R4 stable in pulse", mem_addr, win_addr);
        end
        chk(mem_dq_oe, "R6 bus driven in pulse", mem_dq_oe, 1);
        last_dq = mem_dq_i;
      end else if (win_prev) begin
        chk(pulse * CLK >= T_PWE, "R3 pulse ns", pulse * CLK, T_PWE);
        chk(dstab * CLK >= T_SD, "R3 setup ns", dstab * CLK, T_SD);
        begin
          automatic logic [15:0] w = ram_word(win_addr);
          for (int l = 0; l < 2; l++) if (!win_be[l]) w[l*8 +: 8] = last_dq[l*8 +: 8];
          mem[int'(win_addr)] = w;
        end
      end
      if (!mem_ce_n) begin
        span++;
        if (win) span_wr = 1;
      end else if (!prev_ce_n) begin
        if (span_wr) chk(span * CLK >= T_WC, "R3 cycle ns", span * CLK, T_WC);
        span = 0; span_wr = 0;
      end
      win_prev = win; prev_ce_n = mem_ce_n; prev_addr = mem_addr; prev_oe = mem_dq_oe;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic rd; logic [15:0] exp; } sb_t;
  sb_t sbq[$];
  logic [15:0] shadow [int];

  function automatic logic [15:0] sh_word(input logic [16:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
  endfunction

  task automatic do_req(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    sb_t it;
    logic [15:0] w;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    w = sh_word(a);
    it.rd = !wr; it.exp = '0;
    for (int l = 0; l < 2; l++) begin
      if (wr && m[l]) w[l*8 +: 8] = d[l*8 +: 8];
      if (!wr && m[l]) it.exp[l*8 +: 8] = w[l*8 +: 8];
    end
    if (wr) shadow[int'(a)] = w;
    sbq.push_back(it);
    n_req++;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8 ready low after accept", req_ready, 0);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(req_ready && sbq.size() == 0));
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (sbq.size() == 0) chk(0, "R8 done without request", 1, 0);
      else begin
        automatic sb_t it = sbq.pop_front();
        n_done++;
        if (it.rd) chk(rsp_rdata == it.exp, "R5 read data", rsp_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    // R1: pins during reset
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
        "R1 pins in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 6'b111110);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
        "R1 idle after reset", {req_ready, mem_ce_n, mem_oe_n}, 3'b111);

    // R2 full word write and read back
    do_req(1, 17'h00010, 16'hA5C3, 2'b11);
    do_req(0, 17'h00010, 16'h0000, 2'b11);
    wait_idle();

    // R2/R4/R6: lower lane only, probe pins
    do_req(1, 17'h00010, 16'h1234, 2'b01);
    chk(!mem_ce_n && mem_we_n && mem_addr == 17'h00010, "R4 address phase", {mem_ce_n, mem_we_n}, 2'b01);
    chk(mem_be_n == 2'b10, "R2 lower lane enable", mem_be_n, 2'b10);
    @(negedge clk);
    chk(!mem_we_n && mem_dq_oe && mem_oe_n, "R6 drive in pulse", {mem_we_n, mem_dq_oe, mem_oe_n}, 3'b011);
    chk(mem_dq_o == 16'h1234, "R6 drive value", mem_dq_o, 16'h1234);
    wait_idle();

    // R2 upper lane only, then reads with each mask (R5 lane zeroing)
    do_req(1, 17'h00010, 16'hBEEF, 2'b10);
    do_req(0, 17'h00010, 16'h0, 2'b11);
    do_req(0, 17'h00010, 16'h0, 2'b01);
    do_req(0, 17'h00010, 16'h0, 2'b10);
    wait_idle();

    // R9: mask 00 write changes nothing; mask 00 read returns zero
    do_req(1, 17'h00010, 16'hFFFF, 2'b00);
    chk(mem_be_n == 2'b11, "R9 no lane enable", mem_be_n, 2'b11);
    do_req(0, 17'h00010, 16'h0, 2'b00);
    do_req(0, 17'h00010, 16'h0, 2'b11);
    wait_idle();

    // R5 read during a read: garbage detection on unwritten location, boundaries
    do_req(0, 17'h1FFFF, 16'h0, 2'b11);
    do_req(1, 17'h1FFFF, 16'h0F0F, 2'b11);  // R7 read-to-write turnaround
    do_req(0, 17'h1FFFF, 16'h0, 2'b11);
    do_req(1, 17'h00000, 16'h7E81, 2'b11);
    do_req(0, 17'h00000, 16'h0, 2'b11);
    wait_idle();

    // mixed back-to-back traffic
    x = 32'h1D2C3B4A;
    for (int i = 0; i < 60; i++) begin
      logic [16:0] a;
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      case (x[2:0])
        3'd0: a = 17'h00000;  3'd1: a = 17'h00001;
        3'd2: a = 17'h00002;  3'd3: a = 17'h1FFFE;
        3'd4: a = 17'h1FFFF;  default: a = 17'h00010;
      endcase
      do_req(x[3], a, x[31:16], x[5:4]);
    end
    wait_idle();

    chk(n_done == n_req, "R8 one done per request", n_done, n_req);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle at end", {req_ready, mem_ce_n}, 2'b11);
    finish_run();
  end

endmodule